// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Non-Maskable Input

This block collects interrupt requests from three kinds of source. The first is a single non-maskable pin. The second is four external request pins. The third is a parameterized set of on-chip peripheral request lines. External pins are synchronized and can be sensed by level or by edge. Each maskable source carries a 4-bit priority. The block compares the most urgent pending request with the processor's current 4-bit mask level. It then presents one accepted request to the processor, with its source number and its priority level.

When the processor acknowledges, the block does two things. It returns the mask level that the processor should load. It also clears the latched request of the acknowledged source. Edge and sense modes and all priorities are set through a small write-only register port. Vector lookup and exception sequencing belong to the processor.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Writing address 2+k sets the 4-bit priority of maskable source k from `cfg_wdata[3:0]`. Sources k=0..3 are external pins IRQ0..IRQ3 and k=4+j is peripheral j. The value 1111 is the most urgent and every priority resets to 0.
- R2: A source whose priority is 0 is never reported as an accepted request.
- R3: A pending non-maskable request is always accepted, whatever the value of `cpu_mask`, including 15. It is reported with `req_id`=0 and `req_level`=16, and it takes precedence over every maskable source.
- R4: Bit 0 of address 0 selects the non-maskable edge. 1 means rising and 0 (the reset value) means falling. That pin is always edge sensed.
- R5: While the non-maskable request is the accepted one, `new_mask` is 15.
- R6: Address 1 holds a 2-bit mode per external pin, with bits [2k+1:2k] belonging to IRQk. The codes are 00 = low level (reset), 01 = falling edge, 10 = rising edge and 11 = low level.
- R7: A maskable request is accepted only when its priority is strictly greater than `cpu_mask`.
- R8: Source IDs are 0 for the non-maskable pin, 1..4 for IRQ0..IRQ3 and 5+j for peripheral j. Among pending maskable sources of equal top priority, the lowest ID is reported.
- R9: An edge-sensed request stays pending until an acknowledge (`ack` high while `req_valid` is high) names that source. If a new edge arrives in the acknowledge cycle, the request stays pending.
- R10: A level-sensed external request is not latched. It is pending only while its synchronized pin reads low.
- R11: External pins pass through two synchronizing flops. A pin change sampled at clock edge n makes a level request visible after edge n+1 and an edge request visible after edge n+2. The synchronizers reset to idle: non-maskable pin low, IRQ pins high.
- R12: While a maskable request is accepted, `new_mask` equals that request's priority.
- R13: Peripheral lines are active-high level requests. They are used without synchronization and an acknowledge does not affect them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable request pin |
| irq_pin | input | 4 | External request pins IRQ0..IRQ3 |
| per_req | input | N_PER | Peripheral request lines, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | 8 | Register write data |
| cpu_mask | input | 4 | Processor's current mask level |
| ack | input | 1 | Processor acknowledge of the presented request |
| req_valid | output | 1 | An accepted request is presented |
| req_id | output | ID_W | Source ID of the presented request |
| req_level | output | 5 | Priority of the presented request (16 for non-maskable) |
| new_mask | output | 4 | Mask level to load on acknowledge |

## Verification
Some properties are checked on every cycle. A presented maskable request must always exceed the mask and never have priority zero. A latched non-maskable request must always win and return mask 15. An unacknowledged edge request in edge mode must persist. Other behaviour can only be shown by the bench scenarios against its behavioural model. That covers synchronizer latency, the choice of edge polarity, tie-breaking by ID, level requests dropping on release, and acknowledges that clear only the named source.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_PER = 4,
  localparam int N_MSK = N_PER + 4,
  localparam int ID_W = $clog2(N_PER + 5),
  localparam int ADDR_W = $clog2(N_PER + 6)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_pin,
  input  logic [3:0]        irq_pin,
  input  logic [N_PER-1:0]  per_req,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [3:0]        cpu_mask,
  input  logic              ack,
  output logic              req_valid,
  output logic [ID_W-1:0]   req_id,
  output logic [4:0]        req_level,
  output logic [3:0]        new_mask
);

  logic       nmi_s1, nmi_s2, nmi_prev, nmi_flag, nmi_rise_sel;
  logic [3:0] irq_s1, irq_s2, irq_prev, irq_flag, irq_edge, irq_hit, irq_clr;
  logic [7:0] irq_mode;
  logic [3:0] prio [N_MSK];
  logic [N_MSK-1:0] pend;
  logic [3:0] best_p;
  logic [ID_W-1:0] best_i;
  logic take, nmi_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {nmi_s1, nmi_s2, nmi_prev} <= '0;
      irq_s1 <= '1; irq_s2 <= '1; irq_prev <= '1;
    end else begin
      {nmi_prev, nmi_s2, nmi_s1} <= {nmi_s2, nmi_s1, nmi_pin};
      irq_prev <= irq_s2; irq_s2 <= irq_s1; irq_s1 <= irq_pin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_rise_sel <= 1'b0;
      irq_mode <= '0;
      for (int k = 0; k < N_MSK; k++) prio[k] <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == '0) nmi_rise_sel <= cfg_wdata[0];
      if (cfg_addr == ADDR_W'(1)) irq_mode <= cfg_wdata;
      for (int k = 0; k < N_MSK; k++)
        if (cfg_addr == ADDR_W'(k + 2)) prio[k] <= cfg_wdata[3:0];
    end
  end

  assign nmi_hit = nmi_rise_sel ? (nmi_s2 & ~nmi_prev) : (~nmi_s2 & nmi_prev);
  assign take = ack & req_valid;

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_irq
      assign irq_edge[g] = irq_mode[2*g+1] ^ irq_mode[2*g];
      assign irq_hit[g]  = irq_mode[2*g] ? (irq_prev[g] & ~irq_s2[g]) : (~irq_prev[g] & irq_s2[g]);
      assign irq_clr[g]  = take & ~nmi_flag & (best_i == ID_W'(g));
      assign pend[g]     = irq_edge[g] ? irq_flag[g] : ~irq_s2[g];
    end
    for (g = 0; g < N_PER; g++) begin : g_per
      assign pend[g+4] = per_req[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_flag <= 1'b0;
      irq_flag <= '0;
    end else begin
      nmi_flag <= nmi_hit | (nmi_flag & ~take);
      irq_flag <= irq_edge & ((irq_edge & irq_hit) | (irq_flag & ~irq_clr));
    end
  end

  always_comb begin
    best_p = '0;
    best_i = '0;
    for (int k = 0; k < N_MSK; k++)
      if (pend[k] && prio[k] > best_p) begin
        best_p = prio[k];
        best_i = ID_W'(k);
      end
  end

  assign req_valid = nmi_flag | (best_p > cpu_mask);
  assign req_id    = nmi_flag ? '0 : best_i + ID_W'(1);
  assign req_level = nmi_flag ? 5'd16 : {1'b0, best_p};
  assign new_mask  = nmi_flag ? 4'd15 : best_p;

  // R3
  nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_flag |-> (req_valid && req_id == '0 && req_level == 5'd16));
  // R5
  nmi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_id == '0) |-> new_mask == 4'd15);
  // R7
  above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_id != '0) |-> req_level > {1'b0, cpu_mask});
  // R2
  no_zero_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_level != 5'd0);
  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_id != '0) |-> {1'b0, new_mask} == req_level);

  generate
    for (g = 0; g < 4; g++) begin : g_hold
      // R9
      edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_edge[g] && irq_flag[g] && !(take && !nmi_flag && req_id == ID_W'(g + 1))) |=> irq_flag[g]);
    end
  endgenerate

endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int N_PER = 4;
  localparam int NS = N_PER + 5;

  logic clk = 0, rst_n = 0;
  logic nmi_pin = 0;
  logic [3:0] irq_pin = 4'hF;
  logic [N_PER-1:0] per_req = '0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] cpu_mask = '0;
  logic ack = 0;
  logic req_valid;
  logic [3:0] req_id;
  logic [4:0] req_level;
  logic [3:0] new_mask;

  irq_prio_ctrl #(.N_PER(N_PER)) uut (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  string phase = "R1";
  bit done = 0;

  int hist [5][$];
  bit m_flag [5];
  int m_prio [NS-1];
  int m_mode [4];
  bit m_rise;
  bit e_valid; int e_id, e_lvl, e_nm;

  task automatic model_reset();
    for (int p = 0; p < 5; p++) begin
      hist[p] = {};
      for (int d = 0; d < 3; d++) hist[p].push_back(p == 0 ? 0 : 1);
      m_flag[p] = 0;
    end
    for (int k = 0; k < NS-1; k++) m_prio[k] = 0;
    for (int k = 0; k < 4; k++) m_mode[k] = 0;
    m_rise = 0;
  endtask

  function automatic bit src_pending(int s);
    if (s <= 4) begin
      if (m_mode[s-1] == 1 || m_mode[s-1] == 2) return m_flag[s];
      return hist[s][1] == 0;
    end
    return per_req[s-5];
  endfunction

  task automatic exp_calc();
    int bp, bi;
    bp = 0; bi = 0;
    if (m_flag[0]) begin
      e_valid = 1; e_id = 0; e_lvl = 16; e_nm = 15;
      return;
    end
    for (int s = 1; s < NS; s++)
      if (src_pending(s) && m_prio[s-1] > bp) begin bp = m_prio[s-1]; bi = s; end
    e_valid = bp > int'(cpu_mask);
    e_id = bi; e_lvl = bp; e_nm = bp;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit take, hit, rise, fall;
      int pins [5];
      exp_calc();
      take = ack && e_valid;
      rise = hist[0][1] == 1 && hist[0][2] == 0;
      fall = hist[0][1] == 0 && hist[0][2] == 1;
      hit = m_rise ? rise : fall;
      m_flag[0] = hit || (m_flag[0] && !(take && e_id == 0));
      for (int k = 0; k < 4; k++) begin
        rise = hist[k+1][1] == 1 && hist[k+1][2] == 0;
        fall = hist[k+1][1] == 0 && hist[k+1][2] == 1;
        hit = (m_mode[k] == 1 && fall) || (m_mode[k] == 2 && rise);
        if (m_mode[k] == 1 || m_mode[k] == 2)
          m_flag[k+1] = hit || (m_flag[k+1] && !(take && e_id == k+1));
        else m_flag[k+1] = 0;
      end
      pins[0] = nmi_pin;
      for (int k = 0; k < 4; k++) pins[k+1] = irq_pin[k];
      for (int p = 0; p < 5; p++) begin
        void'(hist[p].pop_back());
        hist[p].push_front(pins[p]);
      end
      if (cfg_we) begin
        if (cfg_addr == 0) m_rise = cfg_wdata[0];
        else if (cfg_addr == 1) for (int k = 0; k < 4; k++) m_mode[k] = (cfg_wdata >> (2*k)) & 3;
        else if (cfg_addr < NS + 1) m_prio[cfg_addr-2] = cfg_wdata[3:0];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      exp_calc();
      checks++;
      if (req_valid !== e_valid ||
          (e_valid && (int'(req_id) != e_id || int'(req_level) != e_lvl || int'(new_mask) != e_nm))) begin
        errors++;
        $display("FAIL %s: got v=%0b id=%0d lvl=%0d nm=%0d expected v=%0b id=%0d lvl=%0d nm=%0d",
                 phase, req_valid, req_id, req_level, new_mask, e_valid, e_id, e_lvl, e_nm);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    tick();
    cfg_we = 0;
  endtask

  task automatic pulse_ack();
    ack = 1; tick(); ack = 0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    tick(3);
    checks++;
    if (req_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got req_valid=%0b expected 0", req_valid);
    end
    rst_n = 1;
    tick(2);

    phase = "R1"; wr(2, 5); tick(2);
    phase = "R11"; irq_pin[0] = 0; tick(4);
    phase = "R12"; tick(1);
    phase = "R7"; cpu_mask = 5; tick(2); cpu_mask = 4; tick(2); cpu_mask = 0;
    phase = "R10"; irq_pin[0] = 1; tick(4);
    phase = "R2"; irq_pin[1] = 0; tick(4); irq_pin[1] = 1; tick(3);

    phase = "R8"; wr(2, 7); wr(4, 7); irq_pin[0] = 0; irq_pin[2] = 0; tick(4);
    wr(5, 7); wr(3, 7); irq_pin[3] = 0; tick(3);
    wr(6, 7); per_req[0] = 1; tick(2); wr(6, 9); tick(2);
    phase = "R13"; pulse_ack(); tick(2); per_req[0] = 0; tick(2);
    irq_pin = 4'hF; tick(4);

    phase = "R6"; wr(1, 8'b01_10_00_00); wr(5, 11); wr(4, 10); tick(2);
    irq_pin[3] = 0; tick(2); irq_pin[3] = 1; tick(5);
    irq_pin[2] = 0; tick(3); irq_pin[2] = 1; tick(5);
    phase = "R9"; pulse_ack(); tick(3); pulse_ack(); tick(3);
    pulse_ack(); tick(2);
    irq_pin[3] = 0; tick(1); irq_pin[3] = 1; tick(1); ack = 1; tick(1); ack = 0; tick(4);
    pulse_ack(); tick(3);
    wr(1, 0); tick(3);

    phase = "R3"; cpu_mask = 15; irq_pin[0] = 0; tick(3);
    phase = "R4"; nmi_pin = 1; tick(5); nmi_pin = 0; tick(5);
    phase = "R5"; tick(2); pulse_ack(); tick(3);
    phase = "R4"; wr(0, 1); nmi_pin = 1; tick(5);
    phase = "R3"; cpu_mask = 0; tick(2); pulse_ack(); tick(3);
    nmi_pin = 0; tick(5);
    irq_pin[0] = 1; tick(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule